// File: doc/BRIEF.md
# ADC Conversion Sequencer with Interrupt Routing

This block schedules conversions on one shared analog-to-digital converter. It holds sixteen conversion slots. Each slot is configured with a trigger source, an input channel number and an acquisition length in clock cycles. Triggers raise a per-slot pending bit. A fixed-priority arbiter then selects the lowest-numbered pending slot. The sequencer counts out that slot's acquisition window and then asks an external converter for a result, using a request/done handshake. The converter's done strobe carries the result, which is stored in a per-slot result memory.

Each finished conversion produces an end-of-conversion pulse. A slot can also post that event to one of four interrupt flags. A flag can run in continuous mode or in one-shot mode. In continuous mode every posting gives a new interrupt pulse. In one-shot mode a flag that is still set blocks further pulses until it is cleared. Interrupt pulses on flags 0 and 1 can be fed back as triggers, so a slot re-arms itself and conversions keep running.

Configuration is written one slot at a time through a simple write port. Results are read back through a synchronous read port with a latency of one cycle.

Top module: `adc_seq_top`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_data` into slot `cfg_slot`. The fields are: bits [1:0] trigger source, [5:2] channel, [13:6] acquisition length, [15:14] target flag, [16] post enable, [18:17] feedback select. Reset clears every slot to all-zero.
- R2: The trigger source codes are: 0 = the slot's own bit of `sw_trig`, 1 = `timer_tick`, 2 = `gpio_soc`, 3 = `pwm_soc`. A source that is not selected has no effect on the slot.
- R3: A trigger seen at a clock edge sets the slot's `pending` bit. If the slot is already pending and is not being started at that edge, its `overflow` bit is set instead. The bit stays set until `ovf_clr` is asserted for it.
- R4: When several slots are pending, they are started in ascending slot-number order, one at a time.
- R5: If the trigger is sampled at edge E, `conv_req` rises at edge E + 1 + max(L,1), where L is the acquisition length. `conv_ch` then holds the slot's channel, and `conv_req` stays high until `conv_done` is sampled.
- R6: When `conv_done` is sampled while `conv_req` is high, `conv_req` drops. At the same edge a one-cycle `eoc_pulse` with `eoc_slot` is raised and `conv_data` is stored for the slot. `rd_data` returns the stored value one cycle after `rd_slot` is applied. `conv_done` has no effect while no request is open.
- R7: If a finished slot has post enable set, its target flag is set and may pulse on `int_pulse`, at the same edge as `eoc_pulse`. If post enable is clear, no flag changes. A flag stays set until cleared by `flag_clr`.
- R8: A flag whose `flag_cont` bit is 0 and which is already set gives no new `int_pulse`.
- R9: A flag whose `flag_cont` bit is 1 pulses on every posting, whether or not it is already set.
- R10: Feedback select 1 (or 2) makes a pulse on `int_pulse[0]` (or `int_pulse[1]`) trigger the slot at the next edge. Value 0 disables feedback.
- R11: After reset, `conv_req`, `eoc_pulse`, `int_pulse`, `int_flag`, `pending` and `overflow` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | 4 | Slot written |
| cfg_data | input | 19 | Slot configuration word |
| flag_cont | input | 4 | Continuous mode per flag |
| sw_trig | input | 16 | Software trigger per slot |
| timer_tick | input | 1 | Timer trigger event |
| gpio_soc | input | 1 | External pin trigger event |
| pwm_soc | input | 1 | PWM trigger event |
| ovf_clr | input | 16 | Overflow clear per slot |
| flag_clr | input | 4 | Interrupt flag clear |
| conv_req | output | 1 | Conversion request to converter |
| conv_ch | output | 4 | Channel for the open request |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 12 | Converter result |
| eoc_pulse | output | 1 | End-of-conversion pulse |
| eoc_slot | output | 4 | Slot that just finished |
| int_pulse | output | 4 | Interrupt pulses |
| int_flag | output | 4 | Sticky interrupt flags |
| pending | output | 16 | Pending slots |
| overflow | output | 16 | Overflow bits |
| rd_slot | input | 4 | Result read address |
| rd_data | output | 12 | Result read data |

## Verification
The hardest situation to reach from the ports is a self-sustaining feedback loop that ends only because a one-shot flag is still set. To reach it, the bench acts as the converter for a slot that feeds back from its own target flag. It counts how many conversions arrive with no further external trigger: exactly two with the flag in one-shot mode. With the flag in continuous mode the loop keeps going until the bench switches the flag back to one-shot. Overflow is reached by re-triggering a slot at the edge where a lower slot is being started.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W   = 4;
  localparam int ACQ_W  = 8;
  localparam int FSEL_W = 2;

  typedef enum logic [1:0] {
    SRC_SW   = 2'd0,
    SRC_TMR  = 2'd1,
    SRC_GPIO = 2'd2,
    SRC_PWM  = 2'd3
  } trig_src_e;

  typedef enum logic [1:0] {
    FB_NONE  = 2'd0,
    FB_FLAG0 = 2'd1,
    FB_FLAG1 = 2'd2,
    FB_RSVD  = 2'd3
  } fb_sel_e;

  typedef struct packed {
    fb_sel_e           fb;
    logic              post_en;
    logic [FSEL_W-1:0] flag_sel;
    logic [ACQ_W-1:0]  acq;
    logic [CH_W-1:0]   ch;
    trig_src_e         src;
  } slot_cfg_t;

  localparam int CFG_W = $bits(slot_cfg_t);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  slot_cfg_t            cfg [NUM_SLOTS],
  input  logic [NUM_SLOTS-1:0] sw_trig,
  input  logic                 timer_tick,
  input  logic                 gpio_soc,
  input  logic                 pwm_soc,
  input  logic [1:0]           fb_pulse,
  input  logic [NUM_SLOTS-1:0] take,
  input  logic [NUM_SLOTS-1:0] ovf_clr,
  output logic [NUM_SLOTS-1:0] pend,
  output logic [NUM_SLOTS-1:0] ovf
);
  logic [NUM_SLOTS-1:0] hit;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic ext_hit;
    logic fb_hit;
    always_comb begin
      unique case (cfg[s].src)
        SRC_SW:   ext_hit = sw_trig[s];
        SRC_TMR:  ext_hit = timer_tick;
        SRC_GPIO: ext_hit = gpio_soc;
        default:  ext_hit = pwm_soc;
      endcase
      fb_hit = ((cfg[s].fb == FB_FLAG0) && fb_pulse[0]) ||
               ((cfg[s].fb == FB_FLAG1) && fb_pulse[1]);
      hit[s] = ext_hit || fb_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      ovf  <= '0;
    end else begin
      pend <= (pend & ~take) | hit;
      ovf  <= (ovf & ~ovf_clr) | (hit & pend & ~take);
    end
  end
endmodule

// File: rtl/adc_seq_arb.sv
module adc_seq_arb #(
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] req,
  output logic [SLOT_W-1:0]    pick,
  output logic                 any
);
  always_comb begin
    pick = '0;
    any  = |req;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (req[i]) pick = SLOT_W'(i);
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 any_pend,
  input  logic [SLOT_W-1:0]    pick,
  input  logic [ACQ_W-1:0]     pick_acq,
  input  logic [CH_W-1:0]      pick_ch,
  input  logic                 conv_done,
  output logic [NUM_SLOTS-1:0] take,
  output logic                 conv_req,
  output logic [CH_W-1:0]      conv_ch,
  output logic [SLOT_W-1:0]    cur_slot,
  output logic                 fin,
  output logic                 eoc_pulse,
  output logic [SLOT_W-1:0]    eoc_slot
);
  seq_state_e       state;
  logic [ACQ_W-1:0] cnt;

  always_comb begin
    take = '0;
    if (state == ST_IDLE && any_pend) take[pick] = 1'b1;
    fin = (state == ST_CONV) && conv_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      conv_req  <= 1'b0;
      conv_ch   <= '0;
      cur_slot  <= '0;
      eoc_pulse <= 1'b0;
      eoc_slot  <= '0;
    end else begin
      eoc_pulse <= 1'b0;
      unique case (state)
        ST_IDLE: if (any_pend) begin
          state    <= ST_ACQ;
          cur_slot <= pick;
          conv_ch  <= pick_ch;
          cnt      <= (pick_acq == '0) ? ACQ_W'(1) : pick_acq;
        end
        ST_ACQ: begin
          if (cnt == ACQ_W'(1)) begin
            state    <= ST_CONV;
            conv_req <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: if (conv_done) begin
          state     <= ST_IDLE;
          conv_req  <= 1'b0;
          eoc_pulse <= 1'b1;
          eoc_slot  <= cur_slot;
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_irq.sv
module adc_seq_irq
  import adc_seq_pkg::*;
#(
  parameter int NUM_FLAGS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fin,
  input  logic                 post_en,
  input  logic [FSEL_W-1:0]    flag_sel,
  input  logic [NUM_FLAGS-1:0] cont,
  input  logic [NUM_FLAGS-1:0] clr,
  output logic [NUM_FLAGS-1:0] int_pulse,
  output logic [NUM_FLAGS-1:0] int_flag
);
  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    localparam logic [FSEL_W-1:0] FIDX = FSEL_W'(f);
    logic post_hit;
    assign post_hit = fin && post_en && (flag_sel == FIDX);

    always_ff @(posedge clk) begin
      if (rst) begin
        int_pulse[f] <= 1'b0;
        int_flag[f]  <= 1'b0;
      end else begin
        int_pulse[f] <= post_hit && (cont[f] || !int_flag[f]);
        if (post_hit)    int_flag[f] <= 1'b1;
        else if (clr[f]) int_flag[f] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_FLAGS = 4,
  parameter int RES_W     = 12,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [SLOT_W-1:0]    cfg_slot,
  input  logic [CFG_W-1:0]     cfg_data,
  input  logic [NUM_FLAGS-1:0] flag_cont,
  input  logic [NUM_SLOTS-1:0] sw_trig,
  input  logic                 timer_tick,
  input  logic                 gpio_soc,
  input  logic                 pwm_soc,
  input  logic [NUM_SLOTS-1:0] ovf_clr,
  input  logic [NUM_FLAGS-1:0] flag_clr,
  output logic                 conv_req,
  output logic [CH_W-1:0]      conv_ch,
  input  logic                 conv_done,
  input  logic [RES_W-1:0]     conv_data,
  output logic                 eoc_pulse,
  output logic [SLOT_W-1:0]    eoc_slot,
  output logic [NUM_FLAGS-1:0] int_pulse,
  output logic [NUM_FLAGS-1:0] int_flag,
  output logic [NUM_SLOTS-1:0] pending,
  output logic [NUM_SLOTS-1:0] overflow,
  input  logic [SLOT_W-1:0]    rd_slot,
  output logic [RES_W-1:0]     rd_data
);
  slot_cfg_t            cfg_q [NUM_SLOTS];
  logic [RES_W-1:0]     res_mem [NUM_SLOTS];
  logic [SLOT_W-1:0]    pick;
  logic                 any_pend;
  logic [NUM_SLOTS-1:0] take;
  logic [SLOT_W-1:0]    cur_slot;
  logic                 fin;
  slot_cfg_t            pick_cfg;
  slot_cfg_t            cur_cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SLOTS; s++) cfg_q[s] <= '0;
    end else if (cfg_we) begin
      cfg_q[cfg_slot] <= slot_cfg_t'(cfg_data);
    end
  end

  always_ff @(posedge clk) begin
    if (fin) res_mem[cur_slot] <= conv_data;
    rd_data <= res_mem[rd_slot];
  end

  assign pick_cfg = cfg_q[pick];
  assign cur_cfg  = cfg_q[cur_slot];

  adc_seq_trig #(.NUM_SLOTS(NUM_SLOTS)) trig_i (
    .clk(clk), .rst(rst), .cfg(cfg_q), .sw_trig(sw_trig),
    .timer_tick(timer_tick), .gpio_soc(gpio_soc), .pwm_soc(pwm_soc),
    .fb_pulse(int_pulse[1:0]), .take(take), .ovf_clr(ovf_clr),
    .pend(pending), .ovf(overflow)
  );

  adc_seq_arb #(.NUM_SLOTS(NUM_SLOTS)) arb_i (
    .req(pending), .pick(pick), .any(any_pend)
  );

  adc_seq_ctrl #(.NUM_SLOTS(NUM_SLOTS)) ctrl_i (
    .clk(clk), .rst(rst), .any_pend(any_pend), .pick(pick),
    .pick_acq(pick_cfg.acq), .pick_ch(pick_cfg.ch), .conv_done(conv_done),
    .take(take), .conv_req(conv_req), .conv_ch(conv_ch),
    .cur_slot(cur_slot), .fin(fin), .eoc_pulse(eoc_pulse), .eoc_slot(eoc_slot)
  );

  adc_seq_irq #(.NUM_FLAGS(NUM_FLAGS)) irq_i (
    .clk(clk), .rst(rst), .fin(fin), .post_en(cur_cfg.post_en),
    .flag_sel(cur_cfg.flag_sel), .cont(flag_cont), .clr(flag_clr),
    .int_pulse(int_pulse), .int_flag(int_flag)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_FLAGS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 conv_req,
  input logic                 conv_done,
  input logic                 eoc_pulse,
  input logic [NUM_FLAGS-1:0] int_pulse,
  input logic [NUM_FLAGS-1:0] int_flag,
  input logic [NUM_FLAGS-1:0] flag_cont,
  input logic [NUM_SLOTS-1:0] pending,
  input logic [NUM_SLOTS-1:0] overflow
);
  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (conv_req && !conv_done) |=> conv_req);

  p_req_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (conv_req && conv_done) |=> (!conv_req && eoc_pulse));

  p_eoc_cause_r6: assert property (@(posedge clk) disable iff (rst)
    eoc_pulse |-> $past(conv_req && conv_done));

  p_one_flag_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(int_pulse));

  p_irq_with_eoc_r7: assert property (@(posedge clk) disable iff (rst)
    (|int_pulse) |-> (eoc_pulse && ((int_pulse & ~int_flag) == '0)));

  p_quiet_flag_r8: assert property (@(posedge clk) disable iff (rst)
    ((~$past(flag_cont) & $past(int_flag) & int_pulse) == '0));

  p_ovf_needs_pend_r3: assert property (@(posedge clk) disable iff (rst)
    ((overflow & ~$past(overflow) & ~$past(pending)) == '0));
endmodule

bind adc_seq_top adc_seq_chk #(.NUM_SLOTS(NUM_SLOTS), .NUM_FLAGS(NUM_FLAGS)) chk_i (
  .clk(clk), .rst(rst), .conv_req(conv_req), .conv_done(conv_done),
  .eoc_pulse(eoc_pulse), .int_pulse(int_pulse), .int_flag(int_flag),
  .flag_cont(flag_cont), .pending(pending), .overflow(overflow)
);

// File: tb/adc_seq_top_tb_top.sv
`timescale 1ns/1ps
module adc_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_slot = '0;
  logic [18:0] cfg_data = '0;
  logic [3:0]  flag_cont = '0;
  logic [15:0] sw_trig = '0;
  logic        timer_tick = 1'b0, gpio_soc = 1'b0, pwm_soc = 1'b0;
  logic [15:0] ovf_clr = '0;
  logic [3:0]  flag_clr = '0;
  logic        conv_req;
  logic [3:0]  conv_ch;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic        eoc_pulse;
  logic [3:0]  eoc_slot;
  logic [3:0]  int_pulse, int_flag;
  logic [15:0] pending, overflow;
  logic [3:0]  rd_slot = '0;
  logic [11:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  adc_seq_top dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_data(cfg_data),
    .flag_cont(flag_cont), .sw_trig(sw_trig), .timer_tick(timer_tick),
    .gpio_soc(gpio_soc), .pwm_soc(pwm_soc), .ovf_clr(ovf_clr), .flag_clr(flag_clr),
    .conv_req(conv_req), .conv_ch(conv_ch), .conv_done(conv_done), .conv_data(conv_data),
    .eoc_pulse(eoc_pulse), .eoc_slot(eoc_slot), .int_pulse(int_pulse), .int_flag(int_flag),
    .pending(pending), .overflow(overflow), .rd_slot(rd_slot), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input int s, input int src, input int ch, input int acq,
                           input int flg, input int post, input int fb);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_slot = 4'(s);
    cfg_data = {2'(fb), 1'(post), 2'(flg), 8'(acq), 4'(ch), 2'(src)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fire(input int src, input int s);
    @(negedge clk);
    case (src)
      0: sw_trig[s] = 1'b1;
      1: timer_tick = 1'b1;
      2: gpio_soc   = 1'b1;
      default: pwm_soc = 1'b1;
    endcase
    @(negedge clk);
    sw_trig = '0; timer_tick = 1'b0; gpio_soc = 1'b0; pwm_soc = 1'b0;
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (!conv_req && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic serve(input int data);
    conv_done = 1'b1;
    conv_data = 12'(data);
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    flag_clr = 4'hF;
    @(negedge clk);
    flag_clr = 4'h0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog run did not complete");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(!conv_req && !eoc_pulse && int_pulse == 0, "R11 outputs idle",
          int'({conv_req, eoc_pulse, int_pulse}), 0);
    check(int_flag == 0 && pending == 0 && overflow == 0, "R11 state clear",
          int'(pending | overflow), 0);
    // R6 done without a request is ignored
    serve(12'h5A5);
    check(!eoc_pulse, "R6 stray done ignored", int'(eoc_pulse), 0);

    // R1 R2 R5 R6 R7 sweep over slots, sources and windows
    flag_cont = 4'hF;
    for (int s = 0; s < 16; s++) begin
      for (int src = 0; src < 4; src++) begin
        for (int a = 0; a < 3; a++) begin
          int acq, ch, flg, post, data, exp_n;
          acq  = (a == 0) ? 0 : (a == 1) ? 1 : 4;
          ch   = (s * 5 + src) % 16;
          flg  = (s + src) % 4;
          post = ((s + a) % 3 != 0) ? 1 : 0;
          data = (s * 97 + src * 13 + acq * 7) % 4096;
          exp_n = 1 + ((acq == 0) ? 1 : acq);
          write_cfg(s, src, ch, acq, flg, post, 0);
          fire(src, s);
          wait_req(n);
          check(n == exp_n, "R5 request latency", n, exp_n);
          check(conv_ch == 4'(ch), "R1 channel field", int'(conv_ch), ch);
          serve(data);
          check(eoc_pulse && eoc_slot == 4'(s), "R6 eoc slot", int'(eoc_slot), s);
          check(int_pulse == (post ? 4'(1 << flg) : 4'h0), "R7 post routing",
                int'(int_pulse), post ? (1 << flg) : 0);
          check(int_flag == (post ? 4'(1 << flg) : 4'h0), "R7 flag set",
                int'(int_flag), post ? (1 << flg) : 0);
          check(!conv_req, "R6 request dropped", int'(conv_req), 0);
          rd_slot = 4'(s);
          @(negedge clk);
          check(rd_data == 12'(data), "R6 result readback", int'(rd_data), data);
          check(pending == 0, "R2 no other trigger", int'(pending), 0);
          clear_flags();
          write_cfg(s, 0, 0, 0, 0, 0, 0);
        end
      end
    end

    // R2 unselected sources have no effect on a software-source slot
    write_cfg(6, 0, 6, 1, 0, 0, 0);
    fire(1, 0); fire(2, 0); fire(3, 0);
    check(pending == 0 && !conv_req, "R2 unselected ignored", int'(pending), 0);

    // R3 R4 priority and overflow
    write_cfg(3, 0, 3, 2, 0, 0, 0);
    write_cfg(7, 0, 7, 2, 0, 0, 0);
    write_cfg(12, 0, 12, 2, 0, 0, 0);
    @(negedge clk);
    sw_trig = 16'h1088;
    @(negedge clk);
    sw_trig = 16'h0080;
    @(negedge clk);
    sw_trig = '0;
    check(overflow == 16'h0080, "R3 overflow on repeat", int'(overflow), 16'h0080);
    check(pending == 16'h1080, "R3 pending after start", int'(pending), 16'h1080);
    wait_req(n);
    check(conv_ch == 4'd3, "R4 first lowest", int'(conv_ch), 3);
    serve(1);
    wait_req(n);
    check(conv_ch == 4'd7, "R4 second", int'(conv_ch), 7);
    serve(2);
    wait_req(n);
    check(conv_ch == 4'd12, "R4 third", int'(conv_ch), 12);
    serve(3);
    @(negedge clk);
    check(overflow == 16'h0080, "R3 overflow sticky", int'(overflow), 16'h0080);
    ovf_clr = 16'hFFFF;
    @(negedge clk);
    ovf_clr = '0;
    check(overflow == 0, "R3 overflow cleared", int'(overflow), 0);

    // R8 one-shot flag suppression, R9 continuous
    flag_cont = 4'h0;
    clear_flags();
    write_cfg(2, 0, 2, 1, 2, 1, 0);
    for (int k = 0; k < 3; k++) begin
      if (k == 2) clear_flags();
      fire(0, 2);
      wait_req(n);
      serve(k);
      check(int_pulse == ((k == 1) ? 4'h0 : 4'h4), "R8 one-shot pulse",
            int'(int_pulse), (k == 1) ? 0 : 4);
      check(int_flag == 4'h4, "R8 flag held", int'(int_flag), 4);
    end
    flag_cont = 4'h8;
    write_cfg(2, 0, 2, 1, 3, 1, 0);
    for (int k = 0; k < 3; k++) begin
      fire(0, 2);
      wait_req(n);
      serve(k);
      check(int_pulse == 4'h8, "R9 continuous pulse", int'(int_pulse), 8);
    end
    clear_flags();

    // R10 feedback loop from flag 0, stopped by one-shot flag
    flag_cont = 4'h0;
    write_cfg(9, 0, 9, 1, 0, 1, 1);
    fire(0, 9);
    wait_req(n);
    serve(10);
    check(int_pulse == 4'h1, "R10 first pulse", int'(int_pulse), 1);
    wait_req(n);
    check(conv_req && conv_ch == 4'd9, "R10 feedback retrigger", int'(conv_ch), 9);
    serve(11);
    check(int_pulse == 4'h0, "R8 loop pulse held", int'(int_pulse), 0);
    repeat (20) @(negedge clk);
    check(!conv_req && pending == 0, "R10 loop stops", int'(pending), 0);

    // R10 R9 continuous loop, ended by switching to one-shot
    clear_flags();
    flag_cont = 4'h1;
    fire(0, 9);
    for (int k = 0; k < 4; k++) begin
      wait_req(n);
      check(conv_req, "R10 continuous loop conversion", int'(conv_req), 1);
      serve(k);
      check(int_pulse == 4'h1, "R9 loop pulse", int'(int_pulse), 1);
    end
    flag_cont = 4'h0;
    wait_req(n);
    serve(9);
    check(int_pulse == 4'h0, "R8 loop ends", int'(int_pulse), 0);
    repeat (20) @(negedge clk);
    check(!conv_req, "R10 loop idle", int'(conv_req), 0);

    // R10 feedback from flag 1
    clear_flags();
    write_cfg(9, 0, 9, 0, 0, 0, 0);
    write_cfg(10, 0, 10, 1, 1, 1, 2);
    fire(0, 10);
    wait_req(n);
    serve(20);
    check(int_pulse == 4'h2, "R10 flag1 pulse", int'(int_pulse), 2);
    wait_req(n);
    check(conv_req && conv_ch == 4'd10, "R10 flag1 retrigger", int'(conv_ch), 10);
    serve(21);
    repeat (20) @(negedge clk);
    check(!conv_req, "R10 flag1 stops", int'(conv_req), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule